// File: doc/BRIEF.md
# Transmit Byte FIFO with Descriptor Queue

This block carries outbound data from a host-side producer to a modem-side consumer. It pairs two circular queues. The first is a byte ring that holds payload. The second is a short queue of 14-bit control words, each describing one burst. The producer stores a burst of bytes one per handshake, then commits one control word. That word gives the burst length, a framing mode, an end-of-frame flag and an abort flag. Stored bytes stay hidden from the consumer until a control word that covers them has been committed.

The consumer sees a descriptor-valid flag, takes one control word, and then receives exactly the number of bytes that word names, in write order. A descriptor with the abort flag set still reaches the consumer unchanged, but the bytes it names are dropped inside the block, one per cycle, and are never presented. A commit is refused when it names more bytes than are waiting uncommitted, or when its reserved bit is set. A refused commit raises a one-cycle error pulse. Bytes left over after a partial commit stay pending for a later commit.

Top module: `tx_burst_queue`

## Requirements
- R1: After reset, wr_ready and cw_ready are 1, and dq_valid, rd_valid and cw_err are 0.
- R2: A control word holds the length in bytes in bits [8:0]. Bits [10:9] hold the mode: 00 async, 10 HDLC, 01 raw bitstream, 11 async with multiple stop bits. Bit 12 is end of frame, bit 13 is abort, and bit 11 is reserved (0). Accepted words appear on dq_word unchanged and in commit order.
- R3: After a descriptor of length N without abort is popped, rd_valid is high from the next cycle. Exactly N bytes are delivered in write order, one per cycle in which rd_ready is high, and rd_valid is then low.
- R4: Written bytes that no commit covers never raise dq_valid or rd_valid. dq_valid rises in the cycle after an accepted commit.
- R5: A commit handshake is refused if its length exceeds the number of uncommitted bytes, or if bit 11 is 1. A refused commit pulses cw_err for one cycle, in the cycle after the handshake, and queues no descriptor.
- R6: A commit of length L when P > L bytes are pending publishes the oldest L bytes. The remaining P-L bytes stay pending for a later commit.
- R7: wr_ready is low while the ring holds DATA_DEPTH bytes, counting committed-unread and uncommitted bytes together. A write offered while wr_ready is low is ignored.
- R8: cw_ready is low while DESC_DEPTH descriptors are queued. A commit offered then is neither queued nor flagged as an error.
- R9: dq_valid is high only while the control queue is non-empty and no burst is being delivered. Bytes are presented only after their descriptor has been popped.
- R10: After an abort descriptor of length N is popped, its N bytes are dropped over N cycles with rd_valid low. The bytes of the following burst come out correctly.
- R11: The ring indexes wrap to zero at the buffer end, and bursts that straddle the end come out intact.
- R12: A descriptor of length 0 can be committed with nothing pending. Popping it delivers no bytes, and the next descriptor becomes visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Producer offers a data byte |
| wr_data | input | 8 | Data byte |
| wr_ready | output | 1 | Ring has room for a byte |
| cw_valid | input | 1 | Producer offers a control word |
| cw_word | input | 14 | Control word to commit |
| cw_ready | output | 1 | Control queue has room |
| cw_err | output | 1 | One-cycle pulse after a refused commit |
| dq_valid | output | 1 | A descriptor is available to pop |
| dq_word | output | 14 | Oldest queued control word |
| dq_pop | input | 1 | Consumer takes the descriptor |
| rd_valid | output | 1 | A burst byte is presented |
| rd_data | output | 8 | Burst byte |
| rd_ready | input | 1 | Consumer accepts the byte |

## Verification
Two back-to-back bursts with different modes and flags show whether words and bytes keep their order and boundaries. They also show whether the second descriptor stays hidden while the first drains. Several cases show whether visibility depends on the commit rather than on the writes: holding written bytes uncommitted, committing too long a length, setting the reserved bit, and committing fewer bytes than are pending. A filled ring followed by a full-depth burst that straddles the buffer end exposes errors in the space check, the ignored-write handling and the wrap. An abort burst, a zero-length burst and a filled control queue each check a separate edge case of the delivery controller.

// File: rtl/tbq_pkg.sv
// Shared constants for the transmit burst queue: control word layout.
// Assumes a 14-bit control word with the length in the low bits.
package tbq_pkg;
    localparam int CW_W      = 14;
    localparam int LEN_W     = 9;
    localparam int POS_RSVD  = 11;
    localparam int POS_EOF   = 12;
    localparam int POS_ABORT = 13;

    typedef enum logic [1:0] {
        MODE_ASYNC     = 2'b00,
        MODE_RAW       = 2'b01,
        MODE_HDLC      = 2'b10,
        MODE_ASYNC_MSB = 2'b11
    } frame_mode_e;
endpackage

// File: rtl/tbq_byte_ring.sv
// Circular byte store with three indexes: staged write, committed write, read.
// Writes advance the staged index. A commit moves the committed index forward
// by the burst length. Reads advance the read index.
// Assumes DEPTH is a power of two, so each index wraps to zero at the end.
// Assumes the caller commits no more than is pending and pops only committed bytes.
module tbq_byte_ring #(
    parameter int DEPTH = 64,
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [7:0]       push_data,
    input  logic             commit,
    input  logic [LEN_W-1:0] commit_len,
    input  logic             pop,
    output logic             room,
    output logic [$clog2(DEPTH):0] pending,
    output logic             committed_any,
    output logic [7:0]       head_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] stage_ptr;
    logic [PW-1:0] commit_ptr;
    logic [PW-1:0] read_ptr;
    logic [PW-1:0] fill;

    assign fill          = stage_ptr - read_ptr;
    assign room          = (fill != PW'(DEPTH));
    assign pending       = stage_ptr - commit_ptr;
    assign committed_any = (commit_ptr != read_ptr);
    assign head_data     = mem[read_ptr[AW-1:0]];

    // Store an accepted byte at the staged write position.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[stage_ptr[AW-1:0]] <= push_data;
        end
    end

    // Advance the staged, committed and read indexes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_ptr  <= '0;
            commit_ptr <= '0;
            read_ptr   <= '0;
        end else begin
            if (push)   stage_ptr  <= stage_ptr + 1'b1;
            if (commit) commit_ptr <= commit_ptr + PW'(commit_len);
            if (pop)    read_ptr   <= read_ptr + 1'b1;
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= PW'(DEPTH));

    assert_commit_behind_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_ptr - read_ptr) <= fill);

    assert_pop_committed_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> committed_any);
endmodule

// File: rtl/tbq_desc_queue.sv
// Small circular queue of control words. Each word is written at base plus the
// write index, and the index then advances. Reads come from the read index.
// Assumes DEPTH is a power of two and the caller respects full and empty.
module tbq_desc_queue #(
    parameter int DEPTH = 8,
    parameter int W     = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_word,
    input  logic         pop,
    output logic         full,
    output logic         empty,
    output logic [W-1:0] head_word
);
    localparam int DW = $clog2(DEPTH);
    localparam int PW = DW + 1;

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] wr_idx;
    logic [PW-1:0] rd_idx;
    logic [PW-1:0] count;

    assign count     = wr_idx - rd_idx;
    assign full      = (count == PW'(DEPTH));
    assign empty     = (count == '0);
    assign head_word = slots[rd_idx[DW-1:0]];

    // Write the committed word into its slot.
    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_idx[DW-1:0]] <= push_word;
        end
    end

    // Advance the queue indexes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
        end else begin
            if (push) wr_idx <= wr_idx + 1'b1;
            if (pop)  rd_idx <= rd_idx + 1'b1;
        end
    end

    assert_desc_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PW'(DEPTH));

    assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/tbq_commit_gate.sv
// Decides whether an offered control word is queued or refused.
// A word is refused if its length exceeds the pending byte count or its
// reserved bit is set. A refusal gives a registered one-cycle error pulse.
module tbq_commit_gate #(
    parameter int PW = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cw_valid,
    input  logic [tbq_pkg::CW_W-1:0] cw_word,
    input  logic                  queue_full,
    input  logic [PW-1:0]         pending,
    output logic                  cw_ready,
    output logic                  accept,
    output logic                  cw_err
);
    import tbq_pkg::*;

    logic            offered;
    logic            bad;
    logic [LEN_W-1:0] len;

    assign len      = cw_word[LEN_W-1:0];
    assign cw_ready = !queue_full;
    assign offered  = cw_valid && cw_ready;
    assign bad      = cw_word[POS_RSVD] || (int'(len) > int'(pending));
    assign accept   = offered && !bad;

    // Register the error pulse for a refused handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) cw_err <= 1'b0;
        else        cw_err <= offered && bad;
    end

    assert_err_means_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cw_err |-> !$past(accept));
endmodule

// File: rtl/tbq_drain_ctrl.sv
// Delivers the bytes of one popped burst. When the burst is not aborted, it
// presents one byte per ready cycle. When it is aborted, it drops one byte
// per cycle with rd_valid held low. While busy, no further descriptor is
// offered.
module tbq_drain_ctrl #(
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] start_len,
    input  logic             start_abort,
    input  logic             rd_ready,
    input  logic             bytes_there,
    output logic             busy,
    output logic             rd_valid,
    output logic             consume
);
    logic [LEN_W-1:0] remaining;
    logic             dropping;

    assign rd_valid = busy && !dropping;
    assign consume  = busy && (dropping || rd_ready);

    // Load a burst on pop, count down bytes, and go idle after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            dropping  <= 1'b0;
            remaining <= '0;
        end else if (start) begin
            busy      <= (start_len != '0);
            dropping  <= start_abort;
            remaining <= start_len;
        end else if (consume) begin
            remaining <= remaining - 1'b1;
            if (remaining == LEN_W'(1)) busy <= 1'b0;
        end
    end

    assert_read_committed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> bytes_there);

    assert_busy_has_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remaining != '0));
endmodule

// File: rtl/tx_burst_queue.sv
// Transmit burst queue top: byte ring, control word queue, commit gate and
// burst delivery controller. Bytes become visible only through a committed
// control word, and a descriptor must be popped before its bytes are read.
module tx_burst_queue #(
    parameter int DATA_DEPTH = 64,
    parameter int DESC_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    input  logic [7:0]  wr_data,
    output logic        wr_ready,
    input  logic        cw_valid,
    input  logic [13:0] cw_word,
    output logic        cw_ready,
    output logic        cw_err,
    output logic        dq_valid,
    output logic [13:0] dq_word,
    input  logic        dq_pop,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    input  logic        rd_ready
);
    import tbq_pkg::*;

    localparam int PW = $clog2(DATA_DEPTH) + 1;

    logic          push_byte;
    logic          accept;
    logic          q_full;
    logic          q_empty;
    logic          take;
    logic          busy;
    logic          consume;
    logic          committed_any;
    logic [PW-1:0] pending;

    assign push_byte = wr_valid && wr_ready;
    assign dq_valid  = !q_empty && !busy;
    assign take      = dq_pop && dq_valid;

    tbq_byte_ring #(.DEPTH(DATA_DEPTH), .LEN_W(LEN_W)) u_ring (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (push_byte),
        .push_data    (wr_data),
        .commit       (accept),
        .commit_len   (cw_word[LEN_W-1:0]),
        .pop          (consume),
        .room         (wr_ready),
        .pending      (pending),
        .committed_any(committed_any),
        .head_data    (rd_data)
    );

    tbq_commit_gate #(.PW(PW)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cw_valid  (cw_valid),
        .cw_word   (cw_word),
        .queue_full(q_full),
        .pending   (pending),
        .cw_ready  (cw_ready),
        .accept    (accept),
        .cw_err    (cw_err)
    );

    tbq_desc_queue #(.DEPTH(DESC_DEPTH), .W(CW_W)) u_descq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .push_word(cw_word),
        .pop      (take),
        .full     (q_full),
        .empty    (q_empty),
        .head_word(dq_word)
    );

    tbq_drain_ctrl #(.LEN_W(LEN_W)) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (take),
        .start_len  (dq_word[LEN_W-1:0]),
        .start_abort(dq_word[POS_ABORT]),
        .rd_ready   (rd_ready),
        .bytes_there(committed_any),
        .busy       (busy),
        .rd_valid   (rd_valid),
        .consume    (consume)
    );

    assert_err_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cw_err |=> !cw_err || $past(cw_valid));

    assert_commit_shows_desc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !busy && !take) |=> dq_valid);
endmodule

// File: tb/tx_burst_queue_test.sv
// Directed bench for tx_burst_queue: one task per scenario, each checking its own results.
module tx_burst_queue_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wr_ready;
    logic        cw_valid = 1'b0;
    logic [13:0] cw_word = '0;
    logic        cw_ready;
    logic        cw_err;
    logic        dq_valid;
    logic [13:0] dq_word;
    logic        dq_pop = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        rd_ready = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [7:0] model[$];

    tx_burst_queue uut (.*);

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] cw(input bit ab, input bit eof, input logic [1:0] mode,
                                       input int len);
        return {ab, eof, 1'b0, mode, 9'(len)};
    endfunction

    task automatic write_byte(input logic [7:0] b, output bit acc);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        #1 acc = wr_ready;
        @(negedge clk);
        wr_valid = 1'b0;
        if (acc) model.push_back(b);
    endtask

    task automatic commit(input logic [13:0] w, output bit acc, output bit err);
        @(negedge clk);
        cw_valid = 1'b1;
        cw_word  = w;
        #1 acc = cw_ready;
        @(negedge clk);
        cw_valid = 1'b0;
        err = cw_err;
    endtask

    task automatic pop_desc(input logic [13:0] exp, input string req);
        chk(dq_valid == 1'b1, req, int'(dq_valid), 1);
        chk(dq_word == exp, req, int'(dq_word), int'(exp));
        dq_pop = 1'b1;
        @(negedge clk);
        dq_pop = 1'b0;
    endtask

    task automatic drain(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic [7:0] e;
            e = model.pop_front();
            chk(rd_valid == 1'b1, req, int'(rd_valid), 1);
            chk(rd_data == e, req, int'(rd_data), int'(e));
            chk(dq_valid == 1'b0, "R9", int'(dq_valid), 0);
            @(negedge clk);
        end
        chk(rd_valid == 1'b0, req, int'(rd_valid), 0);
    endtask

    task automatic write_n(input int n, input logic [7:0] base);
        bit a;
        for (int i = 0; i < n; i++) write_byte(base + 8'(i), a);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(wr_ready == 1'b1, "R1", int'(wr_ready), 1);
        chk(cw_ready == 1'b1, "R1", int'(cw_ready), 1);
        chk(dq_valid == 1'b0, "R1", int'(dq_valid), 0);
        chk(rd_valid == 1'b0, "R1", int'(rd_valid), 0);
        chk(cw_err == 1'b0, "R1", int'(cw_err), 0);
    endtask

    task automatic t_order;
        bit a, e;
        write_n(5, 8'h10);
        commit(cw(0, 1, 2'b10, 5), a, e);
        write_n(3, 8'h20);
        commit(cw(0, 0, 2'b01, 3), a, e);
        pop_desc(cw(0, 1, 2'b10, 5), "R2");
        drain(5, "R3");
        pop_desc(cw(0, 0, 2'b01, 3), "R2");
        drain(3, "R3");
    endtask

    task automatic t_hidden;
        bit a, e;
        write_n(4, 8'h30);
        @(negedge clk);
        @(negedge clk);
        chk(dq_valid == 1'b0, "R4", int'(dq_valid), 0);
        chk(rd_valid == 1'b0, "R4", int'(rd_valid), 0);
        commit(cw(0, 1, 2'b00, 4), a, e);
        chk(dq_valid == 1'b1, "R4", int'(dq_valid), 1);
        pop_desc(cw(0, 1, 2'b00, 4), "R4");
        drain(4, "R4");
    endtask

    task automatic t_reject;
        bit a, e;
        write_n(3, 8'h40);
        commit(cw(0, 0, 2'b00, 5), a, e);
        chk(a && e, "R5", int'(e), 1);
        @(negedge clk);
        chk(cw_err == 1'b0, "R5", int'(cw_err), 0);
        chk(dq_valid == 1'b0, "R5", int'(dq_valid), 0);
        commit(cw(0, 0, 2'b00, 3) | 14'h0800, a, e);
        chk(a && e, "R5", int'(e), 1);
        chk(dq_valid == 1'b0, "R5", int'(dq_valid), 0);
        commit(cw(0, 1, 2'b11, 2), a, e);
        chk(e == 1'b0, "R6", int'(e), 0);
        pop_desc(cw(0, 1, 2'b11, 2), "R6");
        drain(2, "R6");
        chk(dq_valid == 1'b0, "R6", int'(dq_valid), 0);
        commit(cw(0, 0, 2'b11, 1), a, e);
        chk(e == 1'b0, "R6", int'(e), 0);
        pop_desc(cw(0, 0, 2'b11, 1), "R6");
        drain(1, "R6");
    endtask

    task automatic t_zero;
        bit a, e;
        commit(cw(0, 1, 2'b10, 0), a, e);
        chk(e == 1'b0, "R12", int'(e), 0);
        write_n(2, 8'h50);
        commit(cw(0, 0, 2'b10, 2), a, e);
        pop_desc(cw(0, 1, 2'b10, 0), "R12");
        chk(rd_valid == 1'b0, "R12", int'(rd_valid), 0);
        pop_desc(cw(0, 0, 2'b10, 2), "R12");
        drain(2, "R12");
    endtask

    task automatic t_abort;
        bit a, e;
        write_n(4, 8'h60);
        commit(cw(1, 1, 2'b10, 4), a, e);
        write_n(2, 8'h70);
        commit(cw(0, 1, 2'b10, 2), a, e);
        pop_desc(cw(1, 1, 2'b10, 4), "R10");
        for (int i = 0; i < 4; i++) begin
            void'(model.pop_front());
            chk(rd_valid == 1'b0, "R10", int'(rd_valid), 0);
            @(negedge clk);
        end
        pop_desc(cw(0, 1, 2'b10, 2), "R10");
        drain(2, "R10");
    endtask

    task automatic t_full_wrap;
        bit a, e;
        for (int i = 0; i < 64; i++) begin
            write_byte(8'(i * 3 + 1), a);
            if (!a) chk(1'b0, "R7", i, 64);
        end
        chk(wr_ready == 1'b0, "R7", int'(wr_ready), 0);
        write_byte(8'hEE, a);
        chk(a == 1'b0, "R7", int'(a), 0);
        commit(cw(0, 1, 2'b00, 64), a, e);
        chk(e == 1'b0, "R11", int'(e), 0);
        pop_desc(cw(0, 1, 2'b00, 64), "R11");
        drain(64, "R11");
        chk(wr_ready == 1'b1, "R7", int'(wr_ready), 1);
    endtask

    task automatic t_desc_full;
        bit a, e;
        write_n(8, 8'h80);
        for (int i = 0; i < 8; i++) commit(cw(0, 0, 2'(i), 1), a, e);
        chk(cw_ready == 1'b0, "R8", int'(cw_ready), 0);
        write_n(1, 8'h90);
        commit(cw(0, 0, 2'b00, 1), a, e);
        chk(a == 1'b0 && e == 1'b0, "R8", int'(e), 0);
        for (int i = 0; i < 8; i++) begin
            pop_desc(cw(0, 0, 2'(i), 1), "R8");
            drain(1, "R8");
        end
        chk(dq_valid == 1'b0, "R8", int'(dq_valid), 0);
        commit(cw(0, 0, 2'b01, 1), a, e);
        pop_desc(cw(0, 0, 2'b01, 1), "R8");
        drain(1, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_order();
        t_hidden();
        t_reject();
        t_zero();
        t_abort();
        t_full_wrap();
        t_desc_full();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule